// File: doc/BRIEF.md
# Indirect-Window Interrupt Redirection Register File

This block holds the programmable state of an I/O interrupt controller behind a two-port indirect window. Software first writes an 8-bit select value, then writes or reads a 32-bit data port. The select value picks one of three things: a small identity register, a constant version word, or half of one of the 64-bit per-pin redirection entries. Each entry therefore spans two consecutive select values.

Beside the storage, the block keeps one pending request bit per pin and one remote-IRR status bit inside each entry. Side inputs set and clear these bits. After every table write it compares the entry's mask before and after the write. If the mask changed, it pulses an event that carries the pin and the new mask value. If the entry is level-triggered and the pin is pending, it pulses a service request for that pin. Both pulses appear in the cycle after the write edge.

Top module: `irq_redir_regfile`

## Requirements
- R1: After reset the select register and ID are zero, every entry reads 0x00010000 in its low half and zero in its high half, and no event or service pulse is active.
- R2: Select 0x01 reads the constant {8'h00, NPINS-1, 8'h00, VERSION} (default 0x00170011); a write there changes no state.
- R3: A write to select 0x00 keeps data bits 27:24 as the ID; select 0x00 reads back the ID in bits 27:24 with all other bits zero.
- R4: A write to select 0x02 has no effect; select 0x02, selects 0x03 to 0x0F and out-of-range selects read zero.
- R5: Select 0x10+2i addresses the low half (bits 31:0) of entry i and 0x11+2i its high half (bits 63:32).
- R6: A high-half write keeps bits 31:0 of the entry, and a low-half write keeps bits 63:32.
- R7: Entry bit 12 (delivery status) and bit 14 (remote-IRR) ignore written data; a low-half write forces bit 14 to zero.
- R8: A table write whose index (select-0x10)>>1 is NPINS or more changes no entry and raises no event or service pulse.
- R9: When a table write changes bit 16 (mask, 1 = masked), mask_evt is high for the one cycle after the write edge with mask_evt_pin = index and mask_evt_val = new mask; otherwise mask_evt stays low.
- R10: After a table write, if the resulting entry has bit 15 set (level trigger) and the pin's pending bit is set, svc_req is high for one cycle with svc_pin = index; edge-triggered or non-pending pins raise nothing.
- R11: req_set[i] sets and req_clr[i] clears the pending bit of pin i (clear wins).
- R12: rirr_set[i] sets bit 14 of entry i and eoi_clr[i] clears it; a high-half write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Load the select register |
| sel_wdata | input | 8 | New select value |
| data_wr | input | 1 | Write data port to the selected register |
| data_wdata | input | 32 | Write data |
| data_rdata | output | 32 | Readback of the selected register |
| req_set | input | NPINS | Set pending bit per pin |
| req_clr | input | NPINS | Clear pending bit per pin |
| rirr_set | input | NPINS | Set remote-IRR per pin |
| eoi_clr | input | NPINS | Clear remote-IRR per pin |
| mask_evt | output | 1 | Mask-change pulse |
| mask_evt_pin | output | $clog2(NPINS) | Pin whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_req | output | 1 | Re-service pulse |
| svc_pin | output | $clog2(NPINS) | Pin to re-service |

## Verification
The assertions take for granted that sel_wr and data_wr are never high in the same cycle, so a data write always uses a settled select value. They also assume that every input is driven to a known level from reset onward. The directed stimulus changes inputs only at falling edges, issues select loads and data writes in separate cycles, and holds all side inputs at zero except during single-cycle pulses.

// File: rtl/irr_pkg.sv
// Package: shared field positions and the entry-merge rule for the
// redirection register file. Assumes 64-bit entries written as 32-bit halves.
package irr_pkg;

    localparam int ENTRY_W    = 64;
    localparam int HALF_W     = 32;
    localparam int BIT_DSTAT  = 12;
    localparam int BIT_RIRR   = 14;
    localparam int BIT_TRIG   = 15;
    localparam int BIT_MASK   = 16;

    localparam logic [7:0]  SEL_ID   = 8'h00;
    localparam logic [7:0]  SEL_VER  = 8'h01;

    // Low-half bits that software cannot write.
    localparam logic [HALF_W-1:0] RO_LO = (32'd1 << BIT_DSTAT) | (32'd1 << BIT_RIRR);

    localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'd1 << BIT_MASK;

    // Apply a 32-bit data-port write to one half of an entry.
    function automatic logic [ENTRY_W-1:0] irr_merge(
        input logic [ENTRY_W-1:0] old_e,
        input logic [HALF_W-1:0]  wd,
        input logic               hi
    );
        logic [ENTRY_W-1:0] r;
        if (hi) begin
            r = {wd, old_e[HALF_W-1:0]};
        end else begin
            r = {old_e[ENTRY_W-1:HALF_W], (wd & ~RO_LO) | (old_e[HALF_W-1:0] & RO_LO)};
            r[BIT_RIRR] = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/irr_window_decode.sv
// Module: holds the 8-bit select register and decodes which target it
// names. Assumes the table starts at TBL_BASE and NPINS*2+TBL_BASE < 512.
module irr_window_decode #(
    parameter int         NPINS    = 24,
    parameter logic [7:0] TBL_BASE = 8'h10,
    localparam int        IDXW     = $clog2(NPINS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_wr,
    input  logic [7:0]      sel_wdata,
    output logic [7:0]      sel_q,
    output logic            hit_id,
    output logic            hit_ver,
    output logic            hit_tbl,
    output logic            tbl_hi,
    output logic [IDXW-1:0] tbl_idx
);
    import irr_pkg::*;

    logic [8:0] offset;
    logic [8:0] slot;

    // Select register load.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 8'h00;
        else if (sel_wr) sel_q <= sel_wdata;
    end

    // Target decode from the stored select.
    always_comb begin
        offset  = {1'b0, sel_q} - {1'b0, TBL_BASE};
        slot    = {1'b0, offset[8:1]};
        hit_id  = (sel_q == SEL_ID);
        hit_ver = (sel_q == SEL_VER);
        hit_tbl = (sel_q >= TBL_BASE) && (slot < 9'(NPINS));
        tbl_hi  = offset[0];
        tbl_idx = offset[IDXW:1];
    end

endmodule

// File: rtl/irr_entry_store.sv
// Module: per-pin 64-bit entry storage. Applies remote-IRR set/clear from
// side inputs, then any data-port write to one half. Assumes at most one
// table write per cycle.
module irr_entry_store #(
    parameter int  NPINS = 24,
    localparam int IDXW  = $clog2(NPINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_tbl,
    input  logic                   wr_hi,
    input  logic [IDXW-1:0]        wr_idx,
    input  logic [31:0]            wdata,
    input  logic [NPINS-1:0]       rirr_set,
    input  logic [NPINS-1:0]       eoi_clr,
    output logic [NPINS-1:0][63:0] entries
);
    import irr_pkg::*;

    for (genvar i = 0; i < NPINS; i++) begin : g_ent
        logic [63:0] nxt;

        // Next value: status update first, then the software write.
        always_comb begin
            nxt = entries[i];
            if (eoi_clr[i])  nxt[BIT_RIRR] = 1'b0;
            if (rirr_set[i]) nxt[BIT_RIRR] = 1'b1;
            if (wr_tbl && (wr_idx == IDXW'(i))) nxt = irr_merge(nxt, wdata, wr_hi);
        end

        // Entry register.
        always_ff @(posedge clk) begin
            if (!rst_n) entries[i] <= ENTRY_RST;
            else        entries[i] <= nxt;
        end
    end

endmodule

// File: rtl/irr_event_gen.sv
// Module: tracks per-pin pending bits and produces the registered
// mask-change and re-service pulses that follow a table write.
// Assumes old_entry is the stored entry at wr_idx in the write cycle.
module irr_event_gen #(
    parameter int  NPINS = 24,
    localparam int IDXW  = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_tbl,
    input  logic             wr_hi,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [31:0]      wdata,
    input  logic [63:0]      old_entry,
    input  logic [NPINS-1:0] req_set,
    input  logic [NPINS-1:0] req_clr,
    output logic             mask_evt,
    output logic [IDXW-1:0]  mask_evt_pin,
    output logic             mask_evt_val,
    output logic             svc_req,
    output logic [IDXW-1:0]  svc_pin
);
    import irr_pkg::*;

    logic [NPINS-1:0] pend_q;
    logic [63:0]      new_entry;
    logic             mask_chg;
    logic             want_svc;

    // Pending request bits; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | req_set) & ~req_clr;
    end

    // Result of the write and the two event conditions.
    always_comb begin
        new_entry = irr_merge(old_entry, wdata, wr_hi);
        mask_chg  = wr_tbl && (new_entry[BIT_MASK] != old_entry[BIT_MASK]);
        want_svc  = wr_tbl && new_entry[BIT_TRIG] && pend_q[wr_idx];
    end

    // Registered one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_evt     <= 1'b0;
            mask_evt_pin <= '0;
            mask_evt_val <= 1'b0;
            svc_req      <= 1'b0;
            svc_pin      <= '0;
        end else begin
            mask_evt     <= mask_chg;
            mask_evt_pin <= mask_chg ? wr_idx : '0;
            mask_evt_val <= mask_chg & new_entry[BIT_MASK];
            svc_req      <= want_svc;
            svc_pin      <= want_svc ? wr_idx : '0;
        end
    end

endmodule

// File: rtl/irr_readback.sv
// Module: combinational readback mux for the data port.
// Assumes decode flags are mutually exclusive.
module irr_readback #(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h11,
    localparam int        IDXW    = $clog2(NPINS)
) (
    input  logic                   hit_id,
    input  logic                   hit_ver,
    input  logic                   hit_tbl,
    input  logic                   tbl_hi,
    input  logic [IDXW-1:0]        tbl_idx,
    input  logic [3:0]             id_q,
    input  logic [NPINS-1:0][63:0] entries,
    output logic [31:0]            rdata
);
    localparam logic [7:0] MAX_IDX = 8'(NPINS - 1);

    logic [63:0] sel_entry;

    // Pick the selected register's 32-bit view.
    always_comb begin
        sel_entry = entries[tbl_idx];
        rdata     = 32'h0;
        if (hit_id)       rdata = {4'h0, id_q, 24'h0};
        else if (hit_ver) rdata = {8'h00, MAX_IDX, 8'h00, VERSION};
        else if (hit_tbl) rdata = tbl_hi ? sel_entry[63:32] : sel_entry[31:0];
    end

endmodule

// File: rtl/irq_redir_regfile.sv
// Module: top of the indirect-window redirection register file. Ties the
// select decode, ID register, entry storage, event generation and readback.
// Assumes sel_wr and data_wr are not asserted together.
module irq_redir_regfile #(
    parameter int         NPINS    = 24,
    parameter logic [7:0] VERSION  = 8'h11,
    parameter logic [7:0] TBL_BASE = 8'h10,
    localparam int        IDXW     = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [7:0]       sel_wdata,
    input  logic             data_wr,
    input  logic [31:0]      data_wdata,
    output logic [31:0]      data_rdata,
    input  logic [NPINS-1:0] req_set,
    input  logic [NPINS-1:0] req_clr,
    input  logic [NPINS-1:0] rirr_set,
    input  logic [NPINS-1:0] eoi_clr,
    output logic             mask_evt,
    output logic [IDXW-1:0]  mask_evt_pin,
    output logic             mask_evt_val,
    output logic             svc_req,
    output logic [IDXW-1:0]  svc_pin
);
    logic [7:0]             sel_q;
    logic                   hit_id;
    logic                   hit_ver;
    logic                   hit_tbl;
    logic                   tbl_hi;
    logic [IDXW-1:0]        tbl_idx;
    logic [3:0]             id_q;
    logic                   wr_tbl;
    logic [NPINS-1:0][63:0] entries;

    irr_window_decode #(.NPINS(NPINS), .TBL_BASE(TBL_BASE)) u_dec (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .sel_q(sel_q), .hit_id(hit_id), .hit_ver(hit_ver), .hit_tbl(hit_tbl),
        .tbl_hi(tbl_hi), .tbl_idx(tbl_idx)
    );

    assign wr_tbl = data_wr & hit_tbl;

    // ID register: only data bits 27:24 are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                id_q <= 4'h0;
        else if (data_wr && hit_id) id_q <= data_wdata[27:24];
    end

    irr_entry_store #(.NPINS(NPINS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_tbl(wr_tbl), .wr_hi(tbl_hi),
        .wr_idx(tbl_idx), .wdata(data_wdata), .rirr_set(rirr_set),
        .eoi_clr(eoi_clr), .entries(entries)
    );

    irr_event_gen #(.NPINS(NPINS)) u_evt (
        .clk(clk), .rst_n(rst_n), .wr_tbl(wr_tbl), .wr_hi(tbl_hi),
        .wr_idx(tbl_idx), .wdata(data_wdata), .old_entry(entries[tbl_idx]),
        .req_set(req_set), .req_clr(req_clr), .mask_evt(mask_evt),
        .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val),
        .svc_req(svc_req), .svc_pin(svc_pin)
    );

    irr_readback #(.NPINS(NPINS), .VERSION(VERSION)) u_rd (
        .hit_id(hit_id), .hit_ver(hit_ver), .hit_tbl(hit_tbl), .tbl_hi(tbl_hi),
        .tbl_idx(tbl_idx), .id_q(id_q), .entries(entries), .rdata(data_rdata)
    );

endmodule

// File: rtl/irr_checker.sv
// Module: protocol and behaviour checks for irq_redir_regfile, attached
// by bind. Assumes inputs are known from reset onward.
module irr_checker #(
    parameter int         NPINS    = 24,
    parameter logic [7:0] TBL_BASE = 8'h10,
    localparam int        IDXW     = $clog2(NPINS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            data_wr,
    input logic [31:0]     data_wdata,
    input logic [7:0]      sel_q,
    input logic [3:0]      id_q,
    input logic            mask_evt,
    input logic [IDXW-1:0] mask_evt_pin,
    input logic            svc_req
);
    localparam logic [8:0] TBL_END = 9'(TBL_BASE) + 9'(2 * NPINS);

    logic oob;
    assign oob = ({1'b0, sel_q} >= TBL_END);

    a_r3_id_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && sel_q == 8'h00) |=> (id_q == $past(data_wdata[27:24])));

    a_r4_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && sel_q == 8'h00) |=> $stable(id_q));

    a_r8_oob_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && oob) |=> (!mask_evt && !svc_req));

    a_r9_evt_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt |-> $past(data_wr));

    a_r9_pin_range: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt |-> (int'(mask_evt_pin) < NPINS));

    a_r10_svc_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> $past(data_wr));

endmodule

bind irq_redir_regfile irr_checker #(.NPINS(NPINS), .TBL_BASE(TBL_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_wdata(data_wdata),
    .sel_q(sel_q), .id_q(id_q), .mask_evt(mask_evt),
    .mask_evt_pin(mask_evt_pin), .svc_req(svc_req)
);

// File: tb/irq_redir_regfile_bench.sv
module irq_redir_regfile_bench;
    localparam int N    = 24;
    localparam int IDXW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sel_wr = 1'b0;
    logic [7:0]      sel_wdata = 8'h00;
    logic            data_wr = 1'b0;
    logic [31:0]     data_wdata = 32'h0;
    logic [31:0]     data_rdata;
    logic [N-1:0]    req_set = '0;
    logic [N-1:0]    req_clr = '0;
    logic [N-1:0]    rirr_set = '0;
    logic [N-1:0]    eoi_clr = '0;
    logic            mask_evt;
    logic [IDXW-1:0] mask_evt_pin;
    logic            mask_evt_val;
    logic            svc_req;
    logic [IDXW-1:0] svc_pin;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_redir_regfile u_irq_redir_regfile (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .data_wr(data_wr), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .req_set(req_set), .req_clr(req_clr), .rirr_set(rirr_set),
        .eoi_clr(eoi_clr), .mask_evt(mask_evt), .mask_evt_pin(mask_evt_pin),
        .mask_evt_val(mask_evt_val), .svc_req(svc_req), .svc_pin(svc_pin)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic set_sel(input logic [7:0] s);
        @(negedge clk); sel_wr = 1'b1; sel_wdata = s;
        @(negedge clk); sel_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] s, output logic [31:0] v);
        set_sel(s);
        v = data_rdata;
    endtask

    // Write and report the event outputs seen in the next cycle.
    task automatic wr(input logic [7:0] s, input logic [31:0] d, output logic [31:0] ev);
        set_sel(s);
        data_wr = 1'b1; data_wdata = d;
        @(negedge clk); data_wr = 1'b0;
        ev = {8'h0, 3'b0, svc_req, 3'(0), svc_pin, 6'b0, mask_evt, mask_evt_val, 3'(0), mask_evt_pin};
    endtask

    function automatic logic [31:0] evw(input bit sv, input int sp, input bit me, input bit mv, input int mp);
        return {8'h0, 3'b0, sv, 3'(0), 5'(sp), 6'b0, me, mv, 3'(0), 5'(mp)};
    endfunction

    task automatic pulse(ref logic [N-1:0] v, input int pin);
        @(negedge clk); v[pin] = 1'b1;
        @(negedge clk); v[pin] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 mask_evt", 32'(mask_evt), 0);
        chk("R1 svc_req", 32'(svc_req), 0);
        chk("R1 id/select", data_rdata, 32'h0);
        rd(8'h10, v); chk("R1 entry0 lo", v, 32'h0001_0000);
        rd(8'h11, v); chk("R1 entry0 hi", v, 32'h0);
        rd(8'h3E, v); chk("R1 entry23 lo", v, 32'h0001_0000);
    endtask

    task automatic t_version();
        logic [31:0] v;
        rd(8'h01, v); chk("R2 version read", v, 32'h0017_0011);
        wr(8'h01, 32'hFFFF_FFFF, v); chk("R2 version write events", v, 0);
        chk("R2 version after write", data_rdata, 32'h0017_0011);
        rd(8'h00, v); chk("R2 id untouched", v, 32'h0);
    endtask

    task automatic t_id();
        logic [31:0] v;
        wr(8'h00, 32'hABCD_EF12, v);
        chk("R3 id readback", data_rdata, 32'h0B00_0000);
    endtask

    task automatic t_arb();
        logic [31:0] v;
        wr(8'h02, 32'hFFFF_FFFF, v); chk("R4 arb events", v, 0);
        chk("R4 arb reads zero", data_rdata, 32'h0);
        rd(8'h00, v); chk("R4 id unchanged", v, 32'h0B00_0000);
        rd(8'h07, v); chk("R4 gap select zero", v, 32'h0);
    endtask

    task automatic t_halves();
        logic [31:0] v;
        wr(8'h1B, 32'h1234_5678, v); chk("R9 hi write no mask evt", v, 0);
        chk("R5 entry5 hi readback", data_rdata, 32'h1234_5678);
        rd(8'h1A, v); chk("R6 lo kept after hi write", v, 32'h0001_0000);
        wr(8'h1A, 32'h0000_80A5, v); chk("R9 unmask event pin5", v, evw(0, 0, 1, 0, 5));
        chk("R5 entry5 lo readback", data_rdata, 32'h0000_80A5);
        rd(8'h1B, v); chk("R6 hi kept after lo write", v, 32'h1234_5678);
        wr(8'h1A, 32'h0000_80A6, v); chk("R9 no event when mask same", v, 0);
        wr(8'h1A, 32'h0001_80A6, v); chk("R9 mask event value 1", v, evw(0, 0, 1, 1, 5));
    endtask

    task automatic t_ro();
        logic [31:0] v;
        wr(8'h14, 32'h0001_5030, v); chk("R7 ro bits events", v, 0);
        chk("R7 ro bits ignored", data_rdata, 32'h0001_0030);
    endtask

    task automatic t_rirr();
        logic [31:0] v;
        pulse(rirr_set, 3);
        rd(8'h16, v); chk("R12 rirr set", v, 32'h0001_4000);
        wr(8'h17, 32'h5500_0000, v);
        rd(8'h16, v); chk("R12 rirr kept by hi write", v, 32'h0001_4000);
        wr(8'h16, 32'h0001_4000, v);
        chk("R7 lo write clears rirr", data_rdata, 32'h0001_0000);
        pulse(rirr_set, 3);
        pulse(eoi_clr, 3);
        rd(8'h16, v); chk("R12 eoi clears rirr", v, 32'h0001_0000);
    endtask

    task automatic t_service();
        logic [31:0] v;
        pulse(req_set, 7);
        wr(8'h1E, 32'h0000_8030, v); chk("R10 level pending svc", v, evw(1, 7, 1, 0, 7));
        wr(8'h1F, 32'h0, v); chk("R10 hi write re-svc", v, evw(1, 7, 0, 0, 0));
        pulse(req_set, 9);
        wr(8'h22, 32'h0000_0030, v); chk("R10 edge pin no svc", v, evw(0, 0, 1, 0, 9));
        pulse(req_clr, 7);
        wr(8'h1F, 32'h0, v); chk("R11 cleared pin no svc", v, 0);
        wr(8'h24, 32'h0000_8030, v); chk("R10 not pending no svc", v, evw(0, 0, 1, 0, 10));
    endtask

    task automatic t_oob();
        logic [31:0] v;
        wr(8'h3F, 32'hAA00_0000, v);
        chk("R5 last entry hi", data_rdata, 32'hAA00_0000);
        wr(8'h40, 32'h0000_0000, v); chk("R8 oob no events", v, 0);
        chk("R8 oob reads zero", data_rdata, 32'h0);
        rd(8'h10, v); chk("R8 entry0 untouched", v, 32'h0001_0000);
        wr(8'hFF, 32'h0000_8000, v); chk("R8 top select no events", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_version();
        t_id();
        t_arb();
        t_halves();
        t_ro();
        t_rirr();
        t_service();
        t_oob();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule